// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Tags

This block receives asynchronous serial characters on one input line. It rebuilds each character in a receive shift register and writes it into a receive queue. Every queue entry keeps four error flags of its own: framing, parity, break and overrun. A consumer on the host side reads the character and its flags together from the head of the queue. The line is sampled at sixteen ticks per bit. The tick rate comes from the system clock through a fixed divider parameter.

Three inputs select the frame format. The format can be 7 or 8 data bits with an optional even or odd parity bit, or 9 data bits with no parity. Data arrives least significant bit first. The control is one state machine with six states:

- `ST_IDLE` waits for the line to go low.
- `ST_START` goes to `ST_DATA` if the line is still low at mid start bit, and back to `ST_IDLE` if it is high.
- `ST_DATA` samples one bit per 16 ticks. After the last data bit it goes to `ST_PARITY` if parity is in use, otherwise to `ST_STOP`.
- `ST_PARITY` samples the parity bit and goes to `ST_STOP`.
- `ST_STOP` samples the stop bit and stores the character. It goes to `ST_IDLE` if the stop bit is high and to `ST_WAIT_HIGH` if it is low.
- `ST_WAIT_HIGH` waits for the line to go high and then goes to `ST_IDLE`.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset the queue is empty and `rd_valid` is 0.
- R2: In 8-bit mode (`cfg_len`=1) without parity, a well-formed frame is stored with its bits in `rd_data[7:0]` (first received bit in bit 0) and all tags 0.
- R3: In 7-bit mode (`cfg_len`=0) the character appears in `rd_data[6:0]`, and `rd_data[8:7]` reads 0.
- R4: In 9-bit mode (`cfg_len`=2 or 3) no parity bit is expected, even when `cfg_par_en`=1, and the parity tag stays 0.
- R5: With `cfg_par_en`=1 the parity tag (`rd_tags[1]`) is set when the received parity bit breaks even parity (`cfg_par_odd`=0) or odd parity (`cfg_par_odd`=1).
- R6: A stop bit that samples low sets the framing tag (`rd_tags[0]`).
- R7: A frame whose data bits, parity bit and stop bit all sample low is stored as one entry. That entry has data 0, the break tag `rd_tags[2]` set, the framing tag set and the parity tag clear. A new start is searched for only after the line has returned high.
- R8: A low pulse on the line that ends before the middle of the start bit is rejected and stores nothing.
- R9: A character that completes while the queue is full is discarded. The next character that is stored carries the overrun tag (`rd_tags[3]`).
- R10: Entries are read in arrival order. `rd_en` removes the head entry, and `rd_en` on an empty queue has no effect.
- R11: The queue holds at most `DEPTH` entries (384 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Data length: 0 = 7 bits, 1 = 8 bits, 2 or 3 = 9 bits |
| cfg_par_en | input | 1 | Parity bit expected (ignored in 9-bit mode) |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_en | input | 1 | Remove the head entry |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 9 | Head character, right aligned |
| rd_tags | output | 4 | Head tags: bit0 framing, bit1 parity, bit2 break, bit3 overrun |

## Verification
The bench builds the block with `TICK_DIV`=2, so one bit lasts 32 clocks and a full frame fits in a few hundred cycles. It also uses `DEPTH`=4, so a few back-to-back characters fill the queue and bring the discard and overrun-tag path within reach. The 384-entry default is left to the capacity assertion, since filling it would only lengthen the run.

// File: rtl/uart_rx_tag_pkg.sv
package uart_rx_tag_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;

    // bit3 overrun, bit2 break, bit1 parity, bit0 framing
    typedef struct packed {
        logic ovr;
        logic brk;
        logic par;
        logic frm;
    } rx_tags_t;

    localparam int CHAR_W = 9;
    localparam int TAG_W  = 4;

    function automatic logic [3:0] frame_bits(input logic [1:0] len);
        unique case (len)
            2'd0:    return 4'd7;
            2'd1:    return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int TICK_DIV = 26
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          div_q <= '0;
                else if (div_q == DW'(TICK_DIV - 1)) div_q <= '0;
                else                                 div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DW'(TICK_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_tag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              fifo_full,
    output logic              stop_evt,
    output logic              push,
    output logic [CHAR_W-1:0] push_data,
    output rx_tags_t          push_tags
);
    rx_state_e         state, state_nx;
    logic [3:0]        tick_cnt;
    logic [3:0]        bit_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_bit;
    logic              any_one;
    logic              ovr_pend;

    logic [3:0]        nbits;
    logic              use_par;
    logic              bit_samp;
    logic [CHAR_W-1:0] data_al;
    logic              is_brk;

    assign nbits    = frame_bits(cfg_len);
    assign use_par  = cfg_par_en && (nbits != 4'd9);
    assign bit_samp = tick && (tick_cnt == 4'd15);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (!rx) state_nx = ST_START;
            ST_START:     if (tick && tick_cnt == 4'd7)
                              state_nx = rx ? ST_IDLE : ST_DATA;
            ST_DATA:      if (bit_samp && bit_idx == nbits - 4'd1)
                              state_nx = use_par ? ST_PARITY : ST_STOP;
            ST_PARITY:    if (bit_samp) state_nx = ST_STOP;
            ST_STOP:      if (bit_samp) state_nx = rx ? ST_IDLE : ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (rx) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            any_one  <= 1'b0;
            ovr_pend <= 1'b0;
        end else begin
            if (state != state_nx) tick_cnt <= '0;
            else if (tick)         tick_cnt <= tick_cnt + 4'd1;

            if (state == ST_IDLE) begin
                bit_idx <= '0;
                shreg   <= '0;
                par_bit <= 1'b0;
                any_one <= 1'b0;
            end else if (state == ST_DATA && bit_samp) begin
                bit_idx <= bit_idx + 4'd1;
                shreg   <= {rx, shreg[CHAR_W-1:1]};
                any_one <= any_one | rx;
            end else if (state == ST_PARITY && bit_samp) begin
                par_bit <= rx;
                any_one <= any_one | rx;
            end

            if (stop_evt) ovr_pend <= fifo_full;
        end
    end

    // outputs
    always_comb begin
        stop_evt  = (state == ST_STOP) && bit_samp;
        data_al   = shreg >> (4'd9 - nbits);
        is_brk    = !rx && !any_one;
        push      = stop_evt && !fifo_full;
        push_data = is_brk ? '0 : data_al;
        push_tags.ovr = ovr_pend;
        push_tags.brk = is_brk;
        push_tags.par = use_par && !is_brk && (par_bit != ((^data_al) ^ cfg_par_odd));
        push_tags.frm = !rx;
    end
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
    parameter int DEPTH = 384,
    parameter int W     = 13,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_word,
    input  logic          rd_en,
    output logic [W-1:0]  rd_word,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr, do_rd;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_wr && !do_rd)      count <= count + 1'b1;
            else if (do_rd && !do_wr) count <= count - 1'b1;
        end
    end

    assign rd_word = mem[rd_ptr];
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_tag_pkg::*;
#(
    parameter int TICK_DIV = 26,
    parameter int DEPTH    = 384,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int ENT_W   = CHAR_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [CHAR_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tags
);
    logic              rx_s;
    logic              tick;
    logic              fifo_full, fifo_empty;
    logic [CW-1:0]     fifo_cnt;
    logic              stop_evt, push_acc;
    logic [CHAR_W-1:0] push_data;
    rx_tags_t          push_tags;
    logic [ENT_W-1:0]  head;

    rx_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
    );

    rx_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    rx_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .fifo_full(fifo_full), .stop_evt(stop_evt), .push(push_acc),
        .push_data(push_data), .push_tags(push_tags)
    );

    rx_tag_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push_acc), .wr_word({push_tags, push_data}),
        .rd_en(rd_en), .rd_word(head),
        .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
    );

    assign rd_valid = !fifo_empty;
    assign rd_data  = head[CHAR_W-1:0];
    assign rd_tags  = head[ENT_W-1:CHAR_W];
endmodule

// File: rtl/uart_rx_tag_chk.sv
module uart_rx_tag_chk #(
    parameter int DEPTH = 384,
    parameter int CW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] fifo_cnt,
    input logic          fifo_full,
    input logic          stop_evt,
    input logic          push_acc,
    input logic [8:0]    push_data,
    input logic [3:0]    push_tags,
    input logic          rd_en,
    input logic [1:0]    cfg_len
);
    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && fifo_full && !rd_en) |=> $stable(fifo_cnt));

    // R7
    brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc && push_tags[2]) |-> (push_data == 9'd0 && push_tags[0] && !push_tags[1]));

    // R4
    nine_bit_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc && cfg_len[1]) |-> !push_tags[1]);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0 && !push_acc) |=> (fifo_cnt == '0));
endmodule

bind uart_rx_tagged uart_rx_tag_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_cnt(fifo_cnt), .fifo_full(fifo_full),
    .stop_evt(stop_evt), .push_acc(push_acc), .push_data(push_data),
    .push_tags(push_tags), .rd_en(rd_en), .cfg_len(cfg_len)
);

// File: tb/uart_rx_tagged_tb.sv
module uart_rx_tagged_tb;
    localparam int TICK_DIV = 2;
    localparam int DEPTH    = 4;
    localparam int BITCLK   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_valid;
    logic [8:0] rd_data;
    logic [3:0] rd_tags;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;
    bit ovr_pend = 1'b0;
    logic [12:0] model_q[$];

    always #10 clk = ~clk;

    uart_rx_tagged #(.TICK_DIV(TICK_DIV), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_tags(rd_tags)
    );

    // per-clock comparison of occupancy against the model (R10)
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            checks++;
            if (rd_valid !== (model_q.size() != 0)) begin
                errors++;
                $display("FAIL R10 monitor: rd_valid=%b expected %b", rd_valid, model_q.size() != 0);
            end
        end
    end

    function automatic void model_push(input logic [12:0] ent);
        if (model_q.size() == DEPTH) begin
            ovr_pend = 1'b1;
        end else begin
            ent[12] = ovr_pend;
            model_q.push_back(ent);
            ovr_pend = 1'b0;
        end
    endfunction

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] len, input bit pen, input bit podd);
        @(negedge clk);
        cfg_len = len; cfg_par_en = pen; cfg_par_odd = podd;
    endtask

    task automatic send_char(input logic [8:0] d, input int nb, input bit pen, input bit podd,
                             input bit bad_par, input bit stop_hi, input int hold_low);
        logic [8:0] dm;
        logic p, use_p, brk, pe;
        dm    = d & ((9'h1 << nb) - 9'h1);
        use_p = pen && (nb != 9);
        p     = (^dm) ^ podd ^ bad_par;
        mon_en = 1'b0;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(dm[i]);
        if (use_p) drive_bit(p);
        drive_bit(stop_hi);
        for (int i = 0; i < hold_low; i++) drive_bit(1'b0);
        rx_line = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        brk = !stop_hi && (dm == 9'd0) && (!use_p || !p);
        pe  = use_p && bad_par && !brk;
        model_push({1'b0, brk, pe, !stop_hi, dm});
        mon_en = 1'b1;
    endtask

    task automatic pop_check(input string tag);
        logic [12:0] exp;
        mon_en = 1'b0;
        @(negedge clk);
        checks++;
        exp = (model_q.size() != 0) ? model_q[0] : 13'h0;
        if (model_q.size() == 0 || !rd_valid || {rd_tags, rd_data} !== exp) begin
            errors++;
            $display("FAIL %s: valid=%b tags=%b data=%h expected valid=1 tags=%b data=%h",
                     tag, rd_valid, rd_tags, rd_data, exp[12:9], exp[8:0]);
        end
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (model_q.size() != 0) void'(model_q.pop_front());
        mon_en = 1'b1;
    endtask

    task automatic check_empty(input string tag);
        @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: rd_valid=%b expected 0", tag, rd_valid);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_empty("R1");
        mon_en = 1'b1;

        // R2 8-bit, no parity
        set_cfg(2'd1, 1'b0, 1'b0);
        send_char(9'h0A5, 8, 0, 0, 0, 1, 0);
        pop_check("R2");
        // R10 order of several entries
        send_char(9'h03C, 8, 0, 0, 0, 1, 0);
        send_char(9'h081, 8, 0, 0, 0, 1, 0);
        pop_check("R10");
        pop_check("R10");

        // R3 7-bit with even parity, R5 parity error
        set_cfg(2'd0, 1'b1, 1'b0);
        send_char(9'h055, 7, 1, 0, 0, 1, 0);
        pop_check("R3");
        send_char(9'h0FF, 7, 1, 0, 0, 1, 0);
        pop_check("R3");
        send_char(9'h055, 7, 1, 0, 1, 1, 0);
        pop_check("R5");
        set_cfg(2'd1, 1'b1, 1'b1);
        send_char(9'h012, 8, 1, 1, 0, 1, 0);
        pop_check("R5");
        send_char(9'h012, 8, 1, 1, 1, 1, 0);
        pop_check("R5");

        // R4 9-bit ignores parity enable
        set_cfg(2'd2, 1'b1, 1'b0);
        send_char(9'h1C3, 9, 1, 0, 0, 1, 0);
        pop_check("R4");

        // R6 framing error
        set_cfg(2'd1, 1'b0, 1'b0);
        send_char(9'h040, 8, 0, 0, 0, 0, 0);
        pop_check("R6");

        // R7 break with long low hold, then a normal character
        set_cfg(2'd1, 1'b1, 1'b0);
        send_char(9'h000, 8, 1, 0, 0, 0, 3);
        pop_check("R7");
        check_empty("R7");
        send_char(9'h077, 8, 1, 0, 0, 1, 0);
        pop_check("R7");

        // R8 short glitch rejected
        mon_en = 1'b0;
        @(negedge clk);
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        mon_en = 1'b1;
        check_empty("R8");

        // R10 read on empty queue has no effect
        set_cfg(2'd1, 1'b0, 1'b0);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        send_char(9'h05A, 8, 0, 0, 0, 1, 0);
        pop_check("R10");
        check_empty("R10");

        // R9 / R11 fill, discard, overrun tag
        for (int i = 1; i <= DEPTH + 1; i++) send_char(9'(i), 8, 0, 0, 0, 1, 0);
        for (int i = 0; i < DEPTH; i++) pop_check("R11");
        check_empty("R9");
        send_char(9'h066, 8, 0, 0, 0, 1, 0);
        pop_check("R9");
        send_char(9'h067, 8, 0, 0, 0, 1, 0);
        pop_check("R9");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule